// File: doc/BRIEF.md
# Invert-Controlled Integer ALU

This block is a purely combinational integer ALU for a simple processor datapath. The function is not picked from an opcode list. Three controls compose it: a bit that inverts operand A, a bit that inverts operand B, and a 2-bit selector that picks one of four result sources. The four sources are bitwise AND, bitwise OR, the adder output, and a one-bit "less than" indication.

The B-invert bit also feeds the adder carry-in. Setting it together with the adder selector therefore turns addition into two's-complement subtraction. Inverting both operands in front of the AND gate yields NOR. Selecting the set source with B inverted gives a signed set-on-less-than.

Two flags accompany the result:
- A zero flag, which the surrounding control logic uses to resolve an equality branch after a subtraction.
- A signed overflow flag, which is meaningful only when the adder result is selected.

Top module: `inv_alu`

## Requirements
- R1: Selector 2'b00 returns the bitwise AND, and selector 2'b01 returns the bitwise OR, of the operands after the optional inversions.
- R2: With both invert bits low and selector 2'b10, the result is A+B modulo 2^WIDTH.
- R3: With the B-invert bit high, the A-invert bit low and selector 2'b10, the result is A-B modulo 2^WIDTH. This is computed as A plus the complement of B, with carry-in 1.
- R4: With both invert bits high and selector 2'b00, the result is the bitwise NOR of A and B.
- R5: With the B-invert bit high, the A-invert bit low and selector 2'b11, bit 0 of the result is 1 exactly when A is less than B as signed two's-complement numbers, including cases where A-B overflows.
- R6: With selector 2'b10, the overflow flag is 1 exactly when the exact signed sum of the inverted-or-not operands plus the carry-in lies outside the signed WIDTH-bit range.
- R7: The zero flag is 1 exactly when every result bit is 0. In particular, it is 1 for a subtraction of equal operands.
- R8: For selectors 2'b00, 2'b01 and 2'b11, the overflow flag is 0.
- R9: With selector 2'b11, result bits WIDTH-1 down to 1 are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| inv_a_i | input | 1 | Invert operand A before use |
| inv_b_i | input | 1 | Invert operand B before use; also the adder carry-in |
| op_i | input | 2 | Result source: 00 AND, 01 OR, 10 adder, 11 set-on-less |
| res_o | output | WIDTH | Result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of the adder; low for other selectors |

## Verification
No register sits between the inputs and any output. Result, zero flag and overflow flag are all due in the same cycle as the operands and controls that produce them.

The bench changes inputs on the falling clock edge. It compares all three outputs against its behavioural model shortly after the following rising edge, which gives the logic half a period to settle and keeps the samples clear of the edge where inputs change. Directed vectors cover the overflow corners of add, subtract and set-on-less. A pseudo-random sweep over all control combinations follows them.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned ALU_WIDTH_DEF = 32;

    typedef enum logic [1:0] {
        SEL_AND = 2'b00,
        SEL_OR  = 2'b01,
        SEL_SUM = 2'b10,
        SEL_SET = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic     inv_a;
        logic     inv_b;
        alu_sel_e sel;
    } alu_ctl_t;

    function automatic logic cond_invert(input logic bit_in, input logic inv);
        return bit_in ^ inv;
    endfunction

    function automatic logic pick_source(input alu_sel_e sel, input logic and_v,
                                         input logic or_v, input logic sum_v,
                                         input logic set_v);
        logic r;
        case (sel)
            SEL_AND: r = and_v;
            SEL_OR:  r = or_v;
            SEL_SUM: r = sum_v;
            default: r = set_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  alu_ctl_t ctl_i,
    input  logic     sum_i,
    input  logic     less_i,
    output logic     a_eff_o,
    output logic     b_eff_o,
    output logic     res_o
);

    logic and_v;
    logic or_v;

    always_comb begin
        a_eff_o = cond_invert(a_i, ctl_i.inv_a);
        b_eff_o = cond_invert(b_i, ctl_i.inv_b);
        and_v   = a_eff_o & b_eff_o;
        or_v    = a_eff_o | b_eff_o;
        res_o   = pick_source(ctl_i.sel, and_v, or_v, sum_i, less_i);
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o
);

    localparam int unsigned EXT = WIDTH + 1;

    logic [EXT-1:0] full;

    always_comb begin
        full  = {1'b0, a_i} + {1'b0, b_i} + {{(EXT-1){1'b0}}, cin_i};
        sum_o = full[WIDTH-1:0];
    end

endmodule

// File: rtl/alu_sign_unit.sv
module alu_sign_unit
    import alu_pkg::*;
(
    input  logic     a_msb_i,
    input  logic     b_msb_i,
    input  logic     sum_msb_i,
    input  alu_sel_e sel_i,
    output logic     ovf_o,
    output logic     set_o
);

    logic ovf_raw;

    always_comb begin
        ovf_raw = (a_msb_i == b_msb_i) && (sum_msb_i != a_msb_i);
        set_o   = sum_msb_i ^ ovf_raw;
        ovf_o   = (sel_i == SEL_SUM) ? ovf_raw : 1'b0;
    end

endmodule

// File: rtl/inv_alu.sv
module inv_alu
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = ALU_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             ovf_o
);

    localparam int unsigned MSB = WIDTH - 1;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             set_bit;

    always_comb begin
        ctl.inv_a = inv_a_i;
        ctl.inv_b = inv_b_i;
        ctl.sel   = alu_sel_e'(op_i);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less;
        if (i == 0) begin : g_lsb
            assign less = set_bit;
        end else begin : g_upper
            assign less = 1'b0;
        end
        alu_slice u_slice (
            .a_i     (opa_i[i]),
            .b_i     (opb_i[i]),
            .ctl_i   (ctl),
            .sum_i   (sum[i]),
            .less_i  (less),
            .a_eff_o (a_eff[i]),
            .b_eff_o (b_eff[i]),
            .res_o   (res_o[i])
        );
    end

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i   (a_eff),
        .b_i   (b_eff),
        .cin_i (inv_b_i),
        .sum_o (sum)
    );

    alu_sign_unit u_sign (
        .a_msb_i   (a_eff[MSB]),
        .b_msb_i   (b_eff[MSB]),
        .sum_msb_i (sum[MSB]),
        .sel_i     (ctl.sel),
        .ovf_o     (ovf_o),
        .set_o     (set_bit)
    );

    assign zero_o = ~|res_o;

endmodule

// File: rtl/inv_alu_chk.sv
module inv_alu_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             inv_a_i,
    input logic             inv_b_i,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] res_o,
    input logic             zero_o,
    input logic             ovf_o
);

    localparam int unsigned MSB = WIDTH - 1;

    always_comb begin
        if (!inv_a_i && !inv_b_i && op_i == 2'b10) begin
            // R2
            add_result_chk: assert (res_o == opa_i + opb_i);
            // R6
            add_ovf_chk: assert (ovf_o == ((opa_i[MSB] == opb_i[MSB]) && (res_o[MSB] != opa_i[MSB])));
        end
        if (!inv_a_i && inv_b_i && op_i == 2'b10) begin
            // R3
            sub_result_chk: assert (res_o == opa_i - opb_i);
            // R7
            if (opa_i == opb_i) begin
                sub_equal_zero_chk: assert (zero_o);
            end
        end
        if (inv_a_i && inv_b_i && op_i == 2'b00) begin
            // R4
            nor_result_chk: assert (res_o == ~(opa_i | opb_i));
        end
        if (op_i == 2'b11) begin
            // R9
            set_upper_chk: assert (res_o[MSB:1] == '0);
        end
        if (!inv_a_i && inv_b_i && op_i == 2'b11) begin
            // R5
            slt_signed_chk: assert (res_o[0] == ($signed(opa_i) < $signed(opb_i)));
        end
        if (op_i != 2'b10) begin
            // R8
            no_overflow_chk: assert (!ovf_o);
        end
    end

endmodule

bind inv_alu inv_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .inv_a_i (inv_a_i),
    .inv_b_i (inv_b_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .zero_o  (zero_o),
    .ovf_o   (ovf_o)
);

// File: tb/sim_inv_alu.sv
`timescale 1ns/1ps
module sim_inv_alu;

    logic        clk;
    logic        rst;
    logic [31:0] a;
    logic [31:0] b;
    logic        ia;
    logic        ib;
    logic [1:0]  op;
    logic [31:0] res;
    logic        zero;
    logic        ovf;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    inv_alu #(.WIDTH(32)) u0 (
        .opa_i   (a),
        .opb_i   (b),
        .inv_a_i (ia),
        .inv_b_i (ib),
        .op_i    (op),
        .res_o   (res),
        .zero_o  (zero),
        .ovf_o   (ovf)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check_out(input string req, input logic [31:0] er,
                             input logic ez, input logic eo);
        total++;
        if (res !== er || zero !== ez || ovf !== eo) begin
            fails++;
            $display("FAIL %s: a=%h b=%h ia=%0b ib=%0b op=%0d actual res=%h z=%0b v=%0b expected res=%h z=%0b v=%0b",
                     req, a, b, ia, ib, op, res, zero, ovf, er, ez, eo);
        end
    endtask

    task automatic run(input string req, input logic [31:0] va, input logic [31:0] vb,
                       input logic via, input logic vib, input logic [1:0] vop);
        logic [31:0] aa;
        logic [31:0] bb;
        logic [31:0] er;
        longint      s;
        logic        big;
        @(negedge clk);
        a = va; b = vb; ia = via; ib = vib; op = vop;
        @(posedge clk);
        #2;
        aa  = via ? ~va : va;
        bb  = vib ? ~vb : vb;
        s   = longint'($signed(aa)) + longint'($signed(bb)) + (vib ? 64'sd1 : 64'sd0);
        big = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        case (vop)
            2'b00:   er = aa & bb;
            2'b01:   er = aa | bb;
            2'b10:   er = s[31:0];
            default: er = (s < 0) ? 32'd1 : 32'd0;
        endcase
        check_out(req, er, (er == 32'd0), (vop == 2'b10) && big);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        rst = 1'b1;
        a = '0; b = '0; ia = 1'b0; ib = 1'b0; op = 2'b00;
        repeat (3) @(posedge clk);
        #2;
        check_out("R7 reset idle", 32'd0, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        run("R1 and",        32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 1'b0, 2'b00);
        run("R1 or",         32'hF000_0001, 32'h000F_0100, 1'b0, 1'b0, 2'b01);
        run("R1 or inverted A", 32'h0000_FFFF, 32'h1200_0000, 1'b1, 1'b0, 2'b01);
        run("R2 add",        32'd1234, 32'd4321, 1'b0, 1'b0, 2'b10);
        run("R2 add wrap",   32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 2'b10);
        run("R6 add pos ovf", 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 2'b10);
        run("R6 add neg ovf", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 2'b10);
        run("R3 sub",        32'd100, 32'd58, 1'b0, 1'b1, 2'b10);
        run("R3 sub negative", 32'd5, 32'd9, 1'b0, 1'b1, 2'b10);
        run("R6 sub ovf",    32'h8000_0000, 32'd1, 1'b0, 1'b1, 2'b10);
        run("R6 sub ovf pos", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'b10);
        run("R7 sub equal",  32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1, 2'b10);
        run("R4 nor",        32'h00FF_0F0F, 32'hF000_00F0, 1'b1, 1'b1, 2'b00);
        run("R4 nor zeros",  32'd0, 32'd0, 1'b1, 1'b1, 2'b00);
        run("R5 slt true",   32'hFFFF_FFFE, 32'd3, 1'b0, 1'b1, 2'b11);
        run("R5 slt false",  32'd7, 32'd7, 1'b0, 1'b1, 2'b11);
        run("R5 slt ovf true",  32'h8000_0000, 32'd1, 1'b0, 1'b1, 2'b11);
        run("R5 slt ovf false", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'b11);
        run("R8 and no ovf", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 2'b00);
        run("R9 set upper",  32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1, 2'b11);

        lf = 32'h1357_9BDF;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            string       tag;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            ra = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            rb = (n % 7 == 0) ? ra : lf;
            case (n % 4)
                0: tag = (n % 8 == 0) ? "R4 sweep" : "R1 sweep";
                1: tag = "R8 sweep";
                2: tag = "R6 sweep";
                default: tag = "R9 sweep";
            endcase
            run(tag, ra, rb, lf[3], lf[7] | (n % 8 == 0), 2'(n % 4));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule